// File: doc/BRIEF.md
# Scrolling Text Frame Composer

This block keeps the picture memory of an eight-row LED banner and makes a text message move across it. Each row is a 24-bit field. Every few display frames all rows move one bit toward the low end. Every few such moves, the next message character is drawn into the high byte of every row, one glyph column at a time. The pixel data comes from an external font store. A matrix scanner reads rows through a side port and pulses `frame_done_i` once it has finished a full scan. The composer changes the picture only on that pulse, or in the few cycles that follow it, so a scan never catches a row in the middle of a move.

The message sits in an external byte store and is read in order from index 0. A zero byte ends one pass of the message: the index wraps to 0, a blank column group is drawn, and the pass counter drops by one. When the last pass ends, the composer freezes the picture and raises a power-down request. The frame divider, the move divider and the pass count are parameters.

Top module: `scroll_composer`

## Requirements
- R1: While `rst_ni` is low, and after it is released, every row reads 0, `msg_addr_o` is 0 and `power_down_o` is 0. The frame counter, the move counter and the pass counter start at their parameter values.
- R2: Every FRAMES_PER_STEP-th accepted `frame_done_i` pulse shifts each 24-bit row right by one bit, with 0 entering bit 23. The other pulses leave the rows unchanged.
- R3: On every STEPS_PER_CHAR-th shift, in the same cycle as that shift, the byte at `msg_addr_o` is taken. A non-zero byte advances `msg_addr_o` by one, wrapping modulo 2^MSG_AW.
- R4: After a character is taken, `font_addr_o` presents (code − 0x20)·5 + k for k = 4, 3, 2, 1, 0 on the five following cycles, one value per cycle.
- R5: On each of those cycles, bits 23:16 of row r become {bits 22:16, bit (7 − r) of `font_data_i`}. As a result, glyph column 0 ends in bit 16 and column 4 ends in bit 20.
- R6: A zero byte sets `msg_addr_o` to 0, decrements the pass counter and draws the glyph of code 0x20.
- R7: A code from 0x01 to 0x1F, or from 0x7E to 0xFF, is drawn as code 0x20. Codes 0x20 to 0x7D are drawn as themselves.
- R8: If the pass counter is 0 once a character's five columns are drawn, `power_down_o` rises on the next cycle and stays high. From then on `frame_done_i` changes neither the rows nor `msg_addr_o`.
- R9: Outside a `frame_done_i` pulse and the five drawing cycles, the rows do not change. A `frame_done_i` that arrives during drawing is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | One-cycle pulse that marks the end of a display scan |
| msg_addr_o | output | MSG_AW | Message byte index |
| msg_data_i | input | 8 | Message byte at `msg_addr_o`, combinational |
| font_addr_o | output | 9 | Font byte address |
| font_data_i | input | 8 | Glyph column at `font_addr_o`, bit 7 is row 0 |
| row_sel_i | input | 3 | Row to read out |
| row_data_o | output | 24 | Contents of the selected row |
| power_down_o | output | 1 | Power-down request, sticky |

## Verification
A wrong counter shows up as a shift or a character arriving on the wrong pulse. The row contents then differ from the computed image right after that pulse. Because every later shift carries the error along, it keeps showing on later pulses too. A wrong glyph address or a wrong bit order corrupts bits 23:16 within the same five-cycle drawing window, and a misplaced pass counter moves the rising edge of `power_down_o` by a whole pass, which is several characters' worth of pulses.

// File: rtl/scroll_pkg.sv
package scroll_pkg;
  localparam int ROWS       = 8;
  localparam int ROW_W      = 24;
  localparam int ENTRY_LSB  = 16;
  localparam int GLYPH_COLS = 5;
  localparam int FONT_AW    = 9;
  localparam int COL_W      = 3;
  localparam logic [7:0] CODE_FIRST = 8'h20;
  localparam logic [7:0] CODE_LAST  = 8'h7D;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_INSERT = 2'd1,
    ST_HALT   = 2'd2
  } comp_state_e;

  function automatic logic [7:0] sanitize_code(input logic [7:0] c);
    if (c < CODE_FIRST || c > CODE_LAST) return CODE_FIRST;
    return c;
  endfunction

  function automatic logic [FONT_AW-1:0] glyph_base(input logic [7:0] c);
    logic [FONT_AW-1:0] off;
    off = FONT_AW'(c - CODE_FIRST);
    return (off << 2) + off;
  endfunction
endpackage

// File: rtl/scroll_timing.sv
module scroll_timing #(
  parameter int FRAMES_PER_STEP = 4,
  parameter int STEPS_PER_CHAR  = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic step_o,
  output logic fetch_o
);
  localparam int FW = (FRAMES_PER_STEP > 1) ? $clog2(FRAMES_PER_STEP) : 1;
  localparam int SW = (STEPS_PER_CHAR > 1) ? $clog2(STEPS_PER_CHAR) : 1;
  localparam logic [FW-1:0] F_LOAD = FW'(FRAMES_PER_STEP - 1);
  localparam logic [SW-1:0] S_LOAD = SW'(STEPS_PER_CHAR - 1);

  logic [FW-1:0] frame_cnt_q;
  logic [SW-1:0] step_cnt_q;

  assign step_o  = tick_i && (frame_cnt_q == '0);
  assign fetch_o = step_o && (step_cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_cnt_q <= F_LOAD;
      step_cnt_q  <= S_LOAD;
    end else if (tick_i) begin
      frame_cnt_q <= step_o ? F_LOAD : frame_cnt_q - 1'b1;
      if (step_o) step_cnt_q <= fetch_o ? S_LOAD : step_cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/scroll_msg_seq.sv
module scroll_msg_seq
  import scroll_pkg::*;
#(
  parameter int MSG_AW  = 6,
  parameter int REPEATS = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fetch_i,
  input  logic [7:0]         msg_data_i,
  output logic [MSG_AW-1:0]  msg_addr_o,
  output logic [FONT_AW-1:0] base_o,
  output logic               passes_done_o
);
  localparam int RW = $clog2(REPEATS + 1);

  logic [MSG_AW-1:0]  idx_q;
  logic [RW-1:0]      rep_q;
  logic [FONT_AW-1:0] base_q;
  logic               is_null;

  assign is_null = (msg_data_i == 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      rep_q  <= RW'(REPEATS);
      base_q <= '0;
    end else if (fetch_i) begin
      base_q <= glyph_base(sanitize_code(msg_data_i));
      if (is_null) begin
        idx_q <= '0;
        if (rep_q != '0) rep_q <= rep_q - 1'b1;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign msg_addr_o    = idx_q;
  assign base_o        = base_q;
  assign passes_done_o = (rep_q == '0);
endmodule

// File: rtl/scroll_frame_buf.sv
module scroll_frame_buf
  import scroll_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  shift_i,
  input  logic                  ins_i,
  input  logic [7:0]            font_col_i,
  input  logic [2:0]            row_sel_i,
  output logic [ROW_W-1:0]      row_data_o,
  output logic [ROWS*ROW_W-1:0] flat_o
);
  logic [ROW_W-1:0] rows_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rows_q[r] <= '0;
      end else if (shift_i) begin
        rows_q[r] <= rows_q[r] >> 1;
      end else if (ins_i) begin
        rows_q[r][ROW_W-1:ENTRY_LSB] <=
          {rows_q[r][ROW_W-2:ENTRY_LSB], font_col_i[7-r]};
      end
    end
    assign flat_o[r*ROW_W +: ROW_W] = rows_q[r];
  end

  assign row_data_o = rows_q[row_sel_i];
endmodule

// File: rtl/scroll_composer.sv
module scroll_composer
  import scroll_pkg::*;
#(
  parameter int FRAMES_PER_STEP = 4,
  parameter int STEPS_PER_CHAR  = 6,
  parameter int REPEATS         = 3,
  parameter int MSG_AW          = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_done_i,
  output logic [MSG_AW-1:0]  msg_addr_o,
  input  logic [7:0]         msg_data_i,
  output logic [FONT_AW-1:0] font_addr_o,
  input  logic [7:0]         font_data_i,
  input  logic [2:0]         row_sel_i,
  output logic [ROW_W-1:0]   row_data_o,
  output logic               power_down_o
);
  comp_state_e          state_q;
  logic [COL_W-1:0]     col_q;
  logic                 tick, step, fetch, ins, passes_done;
  logic [FONT_AW-1:0]   base;
  logic [ROWS*ROW_W-1:0] buf_flat;

  assign tick = frame_done_i && (state_q == ST_RUN);
  assign ins  = (state_q == ST_INSERT);

  scroll_timing #(
    .FRAMES_PER_STEP(FRAMES_PER_STEP),
    .STEPS_PER_CHAR (STEPS_PER_CHAR)
  ) timing_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .step_o (step),
    .fetch_o(fetch)
  );

  scroll_msg_seq #(
    .MSG_AW (MSG_AW),
    .REPEATS(REPEATS)
  ) msg_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fetch_i      (fetch),
    .msg_data_i   (msg_data_i),
    .msg_addr_o   (msg_addr_o),
    .base_o       (base),
    .passes_done_o(passes_done)
  );

  scroll_frame_buf buf_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (step),
    .ins_i     (ins),
    .font_col_i(font_data_i),
    .row_sel_i (row_sel_i),
    .row_data_o(row_data_o),
    .flat_o    (buf_flat)
  );

  assign font_addr_o = base + FONT_AW'(col_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      col_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN: if (fetch) begin
          state_q <= ST_INSERT;
          col_q   <= COL_W'(GLYPH_COLS - 1);
        end
        ST_INSERT: begin
          if (col_q == '0) state_q <= passes_done ? ST_HALT : ST_RUN;
          else             col_q   <= col_q - 1'b1;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign power_down_o = (state_q == ST_HALT);
endmodule

// File: rtl/scroll_composer_chk.sv
module scroll_composer_chk
  import scroll_pkg::*;
#(
  parameter int MSG_AW = 6
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  frame_done_i,
  input logic                  power_down_o,
  input logic [MSG_AW-1:0]     msg_addr_o,
  input logic [7:0]            msg_data_i,
  input logic [FONT_AW-1:0]    font_addr_o,
  input logic                  fetch,
  input logic                  ins,
  input logic [ROWS*ROW_W-1:0] buf_flat
);
  a_r9_buf_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_done_i && !ins) |=> $stable(buf_flat));
  a_r8_halt_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |=> power_down_o);
  a_r8_halt_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    power_down_o |=> ($stable(buf_flat) && $stable(msg_addr_o)));
  a_r6_null_wraps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch && msg_data_i == 8'h00) |=> (msg_addr_o == '0));
  a_r3_addr_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch && msg_data_i != 8'h00) |=> (msg_addr_o == MSG_AW'($past(msg_addr_o) + 1'b1)));
  a_r3_fetch_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch |-> frame_done_i);
  a_r4_font_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins |-> (font_addr_o <= FONT_AW'(469)));
  a_r4_col_descend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins && $past(ins)) |-> (font_addr_o == FONT_AW'($past(font_addr_o) - 1'b1)));
endmodule

bind scroll_composer scroll_composer_chk #(.MSG_AW(MSG_AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .frame_done_i(frame_done_i),
  .power_down_o(power_down_o),
  .msg_addr_o  (msg_addr_o),
  .msg_data_i  (msg_data_i),
  .font_addr_o (font_addr_o),
  .fetch       (fetch),
  .ins         (ins),
  .buf_flat    (buf_flat)
);

// File: tb/scroll_composer_tb_top.sv
module scroll_composer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int FR  = 2;
  localparam int ST  = 3;
  localparam int REP = 2;
  localparam int AW  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_done = 1'b0;
  logic [AW-1:0] msg_addr;
  logic [7:0]    msg_data;
  logic [8:0]    font_addr;
  logic [7:0]    font_data;
  logic [2:0]    row_sel = 3'd0;
  logic [23:0]   row_data;
  logic          pd;

  logic [7:0]  msg_mem [16];
  logic [23:0] ref_rows [8];
  int f_cnt, s_cnt, idx, rep;
  bit halted, finished;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] font_fn(input logic [8:0] a);
    return 8'((a * 29 + 7) & 9'h0FF);
  endfunction

  assign msg_data  = msg_mem[msg_addr];
  assign font_data = font_fn(font_addr);

  scroll_composer #(
    .FRAMES_PER_STEP(FR), .STEPS_PER_CHAR(ST), .REPEATS(REP), .MSG_AW(AW)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .frame_done_i(frame_done),
    .msg_addr_o(msg_addr), .msg_data_i(msg_data),
    .font_addr_o(font_addr), .font_data_i(font_data),
    .row_sel_i(row_sel), .row_data_o(row_data), .power_down_o(pd)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_rows(input string tag);
    for (int r = 0; r < 8; r++) begin
      row_sel = 3'(r);
      #1;
      check(tag, 32'(row_data), 32'(ref_rows[r]));
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pulse();
    bit did_fetch;
    bit was_null;
    bit odd;
    logic [7:0] c, code;
    logic [8:0] base;
    string tag;
    did_fetch = 0; was_null = 0; odd = 0; base = '0; tag = "R9";
    if (!halted) begin
      if (f_cnt == 0) begin
        f_cnt = FR - 1;
        tag = "R2";
        for (int r = 0; r < 8; r++) ref_rows[r] = ref_rows[r] >> 1;
        if (s_cnt == 0) begin
          s_cnt = ST - 1;
          did_fetch = 1;
          c = msg_mem[idx];
          if (c == 8'h00) begin
            was_null = 1; idx = 0; rep--; code = 8'h20;
          end else begin
            idx = (idx + 1) % 16;
            odd = (c < 8'h20 || c > 8'h7D);
            code = odd ? 8'h20 : c;
          end
          base = 9'((code - 8'h20) * 5);
          for (int col = 4; col >= 0; col--) begin
            logic [7:0] fb;
            fb = font_fn(base + 9'(col));
            for (int r = 0; r < 8; r++)
              ref_rows[r][23:16] = {ref_rows[r][22:16], fb[7-r]};
          end
          tag = was_null ? "R6" : (odd ? "R7" : "R5");
        end else s_cnt--;
      end else f_cnt--;
    end
    @(negedge clk) frame_done = 1'b1;
    @(negedge clk) frame_done = 1'b0;
    if (did_fetch) begin
      for (int k = 0; k < 5; k++) begin
        check("R4 font address", 32'(font_addr), 32'(base + 9'(4 - k)));
        @(negedge clk);
      end
    end
    @(negedge clk);
    check_rows(tag);
    check("R3 message index", 32'(msg_addr), 32'(idx));
    if (halted) check("R8 halted index", 32'(msg_addr), 32'(idx));
    if (did_fetch && rep == 0) halted = 1;
    check("R8 power down", 32'(pd), 32'(halted));
    repeat (3) @(negedge clk);
    check_rows("R9 idle stable");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 16; i++) msg_mem[i] = 8'h00;
    msg_mem[0] = 8'h41; msg_mem[1] = 8'h7D; msg_mem[2] = 8'h7E;
    msg_mem[3] = 8'h1F; msg_mem[4] = 8'h20; msg_mem[5] = 8'h61;
    for (int r = 0; r < 8; r++) ref_rows[r] = '0;
    f_cnt = FR - 1; s_cnt = ST - 1; idx = 0; rep = REP; halted = 0;
    repeat (3) @(negedge clk);
    check_rows("R1 reset rows");
    check("R1 reset index", 32'(msg_addr), 32'd0);
    check("R1 reset power", 32'(pd), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_rows("R1 after release");
    for (int p = 0; p < 7 * FR * ST * REP + 12; p++) pulse();
    check("R8 final power", 32'(pd), 32'd1);
    summary();
  end
endmodule